// File: doc/BRIEF.md
# Single-Block AEGIS-128 Authenticated Encryptor

This block encrypts one short measurement and produces a 128-bit authentication tag. It uses the AEGIS-128 state-update structure. The state is five 128-bit words. Each update passes every word through one full AES encryption round, and the five rounds run in parallel in the same cycle. The block takes a 128-bit key, a 128-bit nonce and a plaintext of `MEAS_W` bits (at most 128), and returns a ciphertext of the same width together with the tag. It handles no associated data and no multi-block messages, and it does not decrypt.

A caller presents the key, nonce and plaintext with a one-cycle `start_i` while `busy_o` is low. The block then runs a fixed schedule of 18 state updates, one per cycle:

- ten initialisation updates;
- one message update;
- seven finalisation updates.

When the schedule ends, the block raises `done_o` for one cycle. In that same cycle it publishes the ciphertext and tag, and it holds both until the next operation completes. The schedule never varies, so the latency is known in advance and the logic needs no flow control.

Top module: `aegis1_enc`

## Requirements
- R1: Reset is synchronous and active-low. While `rst_n` is low at a rising edge, `busy_o`, `done_o`, `ct_o` and `tag_o` become 0, and any operation in progress is abandoned.
- R2: A rising edge that samples `start_i` high while `busy_o` is low accepts an operation, and `busy_o` is high from the next cycle. `done_o` rises at the 18th rising edge after the accepting edge, and `busy_o` falls at that same edge.
- R3: While `busy_o` is high, `start_i` and any change of `key_i`, `nonce_i` and `msg_i` have no effect. The result depends only on the operands sampled at the accepting edge, and no second operation follows on its own.
- R4: The initial state is loaded as follows, with byte 0 of a word in bits 127:120:
  - W0 = key⊕nonce
  - W1 = A
  - W2 = B
  - W3 = key⊕A
  - W4 = key⊕B
  - A = 000101020305080d1522375990e97962 (hex) and B = db3d18556dc22ff12011314273b528dd (hex), which are the Fibonacci numbers 0..31 taken modulo 256.
- R5: Every update computes new W0 = Round(W4)⊕W0⊕inj and new Wi = Round(W(i-1))⊕Wi for i = 1..4, using old words only. The ten initialisation updates inject the key in the first, third and every other odd-numbered update, and key⊕nonce in the updates in between.
- R6: The plaintext is padded to 128 bits: it occupies bits 127 down to 128-`MEAS_W`, and the bits below are zero. After initialisation, `ct_o` is the top `MEAS_W` bits of pad⊕W1⊕W4⊕(W2 AND W3). The message update then injects the padded plaintext.
- R7: Each of the seven finalisation updates injects W3⊕{64'd0, 64'(`MEAS_W`)}, using W3 of the state it updates. `tag_o` is W0⊕W1⊕W2⊕W3⊕W4 after the seventh update.
- R8: The round treats byte k (bits 127-8k down to 120-8k) as row k mod 4 and column k div 4. It applies the AES S-box, rotates row r left by r columns, applies the AES column mix over GF(2^8) with polynomial 0x11b, and XORs in the old word of the same index.
- R9: `done_o` is high for exactly one cycle per operation. `ct_o` and `tag_o` change only at the edge that raises `done_o`, and they hold their values until the next such edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a new operation |
| key_i | input | 128 | Secret key, sampled at acceptance |
| nonce_i | input | 128 | Nonce, sampled at acceptance |
| msg_i | input | MEAS_W | Plaintext measurement, sampled at acceptance |
| busy_o | output | 1 | Schedule in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ct_o | output | MEAS_W | Ciphertext of the last completed operation |
| tag_o | output | 128 | Authentication tag of the last completed operation |

## Verification
The bench builds the block with `MEAS_W` = 32. With that width the padding places 96 zero bits under the plaintext, and the length field in the finalisation word differs from the full-block value, so a slip in either shows up. At this width the bench can walk a single one through every bit of the key, the nonce and the plaintext, which reaches every S-box input lane and every column of the mix across the runs. Pseudo-random operands and runs that pulse `start_i` mid-schedule, or reset mid-schedule, complete the coverage.

// File: rtl/aegis1_pkg.sv
// Shared types, constants and GF(2^8) helpers for the single-block encryptor.
// Assumes byte 0 of a 128-bit word sits in bits 127:120.
package aegis1_pkg;
    localparam int WORD_W    = 128;
    localparam int NUM_WORDS = 5;
    localparam int NUM_BYTES = WORD_W / 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [NUM_WORDS-1:0][WORD_W-1:0] state_t;

    // Fibonacci numbers 0..15 and 16..31 modulo 256
    localparam word_t FIB_LO = 128'h000101020305080d1522375990e97962;
    localparam word_t FIB_HI = 128'hdb3d18556dc22ff12011314273b528dd;

    // multiply by x modulo 0x11b
    function automatic logic [7:0] gf_x2(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // general field multiply, shift-and-add
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_x2(sh);
        end
        return acc;
    endfunction

    // S-box: inverse as x^254 (product of x^2..x^128), then affine map
    function automatic logic [7:0] sbox(input logic [7:0] x);
        logic [7:0] sq;
        logic [7:0] inv;
        sq  = x;
        inv = 8'h01;
        for (int k = 1; k < 8; k++) begin
            sq  = gf_mul(sq, sq);
            inv = gf_mul(inv, sq);
        end
        return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                   ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    endfunction
endpackage

// File: rtl/aegis1_aes_round.sv
// One AES encryption round on a 128-bit word: substitution, row rotation,
// column mix, then XOR with the supplied round word. Purely combinational.
// Assumes byte k is row k%4, column k/4.
module aegis1_aes_round
    import aegis1_pkg::*;
(
    input  word_t blk_i,
    input  word_t rk_i,
    output word_t blk_o
);
    logic [7:0] sub_b [NUM_BYTES];
    logic [7:0] shf_b [NUM_BYTES];

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
        localparam int ROW = k % 4;
        localparam int COL = k / 4;
        localparam int SRC = 4 * ((COL + ROW) % 4) + ROW;
        // substitute each byte
        assign sub_b[k] = sbox(blk_i[WORD_W-1-8*k -: 8]);
        // row r takes its byte from column c+r
        assign shf_b[k] = sub_b[SRC];
    end

    for (genvar c = 0; c < 4; c++) begin : g_col
        logic [7:0] a0, a1, a2, a3;
        assign a0 = shf_b[4*c];
        assign a1 = shf_b[4*c+1];
        assign a2 = shf_b[4*c+2];
        assign a3 = shf_b[4*c+3];
        // column mix plus round word
        assign blk_o[WORD_W-1-32*c -: 8]  = gf_x2(a0) ^ gf_x2(a1) ^ a1 ^ a2 ^ a3
                                           ^ rk_i[WORD_W-1-32*c -: 8];
        assign blk_o[WORD_W-9-32*c -: 8]  = a0 ^ gf_x2(a1) ^ gf_x2(a2) ^ a2 ^ a3
                                           ^ rk_i[WORD_W-9-32*c -: 8];
        assign blk_o[WORD_W-17-32*c -: 8] = a0 ^ a1 ^ gf_x2(a2) ^ gf_x2(a3) ^ a3
                                           ^ rk_i[WORD_W-17-32*c -: 8];
        assign blk_o[WORD_W-25-32*c -: 8] = gf_x2(a0) ^ a0 ^ a1 ^ a2 ^ gf_x2(a3)
                                           ^ rk_i[WORD_W-25-32*c -: 8];
    end
endmodule

// File: rtl/aegis1_state_update.sv
// Full state update: five parallel rounds, word i keyed by old word i and fed
// by old word i-1 (wrapping), with the injected word folded into word 0.
module aegis1_state_update
    import aegis1_pkg::*;
(
    input  state_t st_i,
    input  word_t  inj_i,
    output state_t st_o
);
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        word_t rnd;
        aegis1_aes_round u_round (
            .blk_i (st_i[(i + NUM_WORDS - 1) % NUM_WORDS]),
            .rk_i  (st_i[i]),
            .blk_o (rnd)
        );
        if (i == 0) begin : g_inj
            // only word 0 absorbs the injected word
            assign st_o[i] = rnd ^ inj_i;
        end else begin : g_plain
            assign st_o[i] = rnd;
        end
    end
endmodule

// File: rtl/aegis1_seq.sv
// Schedule sequencer: accepts a start when idle, steps through a fixed count
// of updates, then pulses done for one cycle. Ignores start while running.
module aegis1_seq #(
    parameter int INIT_STEPS = 10,
    parameter int FIN_STEPS  = 7,
    localparam int TOTAL     = INIT_STEPS + 1 + FIN_STEPS,
    localparam int CW        = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          accept_o,
    output logic          run_o,
    output logic [CW-1:0] step_o,
    output logic          done_o
);
    localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

    logic          run_q;
    logic [CW-1:0] step_q;
    logic          done_q;

    assign accept_o = start_i && !run_q;
    assign run_o    = run_q;
    assign step_o   = step_q;
    assign done_o   = done_q;

    // advance the step counter and raise the completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            step_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!run_q) begin
                if (start_i) begin
                    run_q  <= 1'b1;
                    step_q <= '0;
                end
            end else if (step_q == LAST) begin
                run_q  <= 1'b0;
                done_q <= 1'b1;
            end else begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    assert_step_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && step_q != LAST) |=> (run_q && step_q == $past(step_q) + 1'b1));

    assert_last_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && step_q == LAST) |=> (!run_q && done_q));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/aegis1_enc.sv
// Single-block authenticated encryptor. Loads the state on an accepted start,
// runs init / message / finalisation updates one per cycle, and publishes the
// ciphertext and tag with a one-cycle done. Assumes 1 <= MEAS_W <= 128.
module aegis1_enc
    import aegis1_pkg::*;
#(
    parameter int MEAS_W     = 128,
    parameter int INIT_STEPS = 10,
    parameter int FIN_STEPS  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [127:0]      key_i,
    input  logic [127:0]      nonce_i,
    input  logic [MEAS_W-1:0] msg_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [MEAS_W-1:0] ct_o,
    output logic [127:0]      tag_o
);
    localparam int TOTAL = INIT_STEPS + 1 + FIN_STEPS;
    localparam int CW    = $clog2(TOTAL);
    localparam logic [CW-1:0] MSG_STEP = CW'(INIT_STEPS);
    localparam logic [CW-1:0] LAST     = CW'(TOTAL - 1);
    localparam word_t LEN_WORD = {64'd0, 64'(MEAS_W)};

    logic          accept, run;
    logic [CW-1:0] step;
    word_t         key_q, nonce_q, pad, inj, ct_full, tag_nx;
    logic [MEAS_W-1:0] msg_q, ct_hold;
    state_t        st_q, st_nx, st_init;

    aegis1_seq #(.INIT_STEPS(INIT_STEPS), .FIN_STEPS(FIN_STEPS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .run_o    (run),
        .step_o   (step),
        .done_o   (done_o)
    );

    aegis1_state_update u_upd (
        .st_i  (st_q),
        .inj_i (inj),
        .st_o  (st_nx)
    );

    assign busy_o = run;

    // initial state from the live operands
    always_comb begin
        st_init[0] = key_i ^ nonce_i;
        st_init[1] = FIB_LO;
        st_init[2] = FIB_HI;
        st_init[3] = key_i ^ FIB_LO;
        st_init[4] = key_i ^ FIB_HI;
    end

    // pad plaintext to a word, derive ciphertext and tag candidates
    always_comb begin
        pad     = word_t'(msg_q) << (WORD_W - MEAS_W);
        ct_full = pad ^ st_q[1] ^ st_q[4] ^ (st_q[2] & st_q[3]);
        tag_nx  = st_nx[0] ^ st_nx[1] ^ st_nx[2] ^ st_nx[3] ^ st_nx[4];
    end

    // choose the word injected by the current step
    always_comb begin
        if (step < MSG_STEP)
            inj = step[0] ? (key_q ^ nonce_q) : key_q;
        else if (step == MSG_STEP)
            inj = pad;
        else
            inj = st_q[3] ^ LEN_WORD;
    end

    // latch operands on acceptance, advance the state while running
    always_ff @(posedge clk) begin
        if (accept) begin
            key_q   <= key_i;
            nonce_q <= nonce_i;
            msg_q   <= msg_i;
            st_q    <= st_init;
        end else if (run) begin
            st_q <= st_nx;
        end
    end

    // hold the ciphertext taken just before the message update
    always_ff @(posedge clk) begin
        if (run && step == MSG_STEP) ct_hold <= ct_full[WORD_W-1 -: MEAS_W];
    end

    // publish results together with the completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ct_o  <= '0;
            tag_o <= '0;
        end else if (run && step == LAST) begin
            ct_o  <= ct_hold;
            tag_o <= tag_nx;
        end
    end

    assert_results_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !done_o) |-> ($stable(ct_o) && $stable(tag_o)));

    assert_operands_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(key_q) && $stable(nonce_q) && $stable(msg_q)));
endmodule

// File: tb/aegis1_enc_bench.sv
module aegis1_enc_bench;
    localparam int MW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [127:0]  key_i = '0, nonce_i = '0;
    logic [MW-1:0] msg_i = '0;
    logic          busy_o, done_o;
    logic [MW-1:0] ct_o;
    logic [127:0]  tag_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit ended = 0;

    logic [7:0]   sbt [256];
    logic [127:0] c_lo, c_hi;

    aegis1_enc #(.MEAS_W(MW)) u_aegis1_enc (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
        .nonce_i(nonce_i), .msg_i(msg_i), .busy_o(busy_o), .done_o(done_o),
        .ct_o(ct_o), .tag_o(tag_o)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !ended) begin
            ended = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog act=%0d exp<=150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 0;
        logic [7:0] aa = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= aa;
            aa = aa[7] ? ((aa << 1) ^ 8'h1b) : (aa << 1);
        end
        return r;
    endfunction

    function automatic logic [127:0] b_round(input logic [127:0] a, input logic [127:0] rk);
        logic [7:0] m [4][4];
        logic [7:0] s [4][4];
        logic [127:0] o;
        for (int k = 0; k < 16; k++) m[k % 4][k / 4] = sbt[a[127 - 8*k -: 8]];
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) s[r][c] = m[r][(c + r) % 4];
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                o[127 - 8*(4*c + r) -: 8] = b_mul(8'd2, s[r][c]) ^ b_mul(8'd3, s[(r+1)%4][c])
                                          ^ s[(r+2)%4][c] ^ s[(r+3)%4][c];
        return o ^ rk;
    endfunction

    function automatic logic [639:0] b_upd(input logic [639:0] s, input logic [127:0] m);
        logic [127:0] w [5];
        logic [127:0] n [5];
        for (int i = 0; i < 5; i++) w[i] = s[639 - 128*i -: 128];
        for (int i = 0; i < 5; i++) n[i] = b_round(w[(i + 4) % 5], w[i]);
        n[0] ^= m;
        return {n[0], n[1], n[2], n[3], n[4]};
    endfunction

    task automatic ref_enc(input logic [127:0] k, input logic [127:0] nc, input logic [MW-1:0] msg,
                           output logic [MW-1:0] ct, output logic [127:0] tg);
        logic [639:0] s;
        logic [127:0] pad, cf;
        s = {k ^ nc, c_lo, c_hi, k ^ c_lo, k ^ c_hi};
        for (int i = 0; i < 10; i++) s = b_upd(s, (i % 2 == 0) ? k : (k ^ nc));
        pad = {msg, {(128-MW){1'b0}}};
        cf = pad ^ s[511:384] ^ s[127:0] ^ (s[383:256] & s[255:128]);
        ct = cf[127 -: MW];
        s = b_upd(s, pad);
        for (int i = 0; i < 7; i++) s = b_upd(s, s[255:128] ^ {64'd0, 64'(MW)});
        tg = s[639:512] ^ s[511:384] ^ s[383:256] ^ s[255:128] ^ s[127:0];
    endtask

    task automatic run_op(input logic [127:0] k, input logic [127:0] nc,
                          input logic [MW-1:0] msg, input bit interfere);
        int cyc;
        logic [MW-1:0] ect;
        logic [127:0]  etg;
        @(negedge clk);
        start_i = 1; key_i = k; nonce_i = nc; msg_i = msg;
        @(negedge clk);
        start_i = 0;
        cyc = 1;
        chk("R2 busy after accept", 128'(busy_o), 128'd1);
        while (done_o !== 1'b1 && cyc < 60) begin
            if (interfere && cyc == 4) begin
                start_i = 1; key_i = ~k; nonce_i = ~nc; msg_i = ~msg;
            end else start_i = 0;
            @(negedge clk);
            cyc++;
        end
        start_i = 0;
        chk("R2 latency", 128'(cyc), 128'd19);
        chk("R2 busy low at done", 128'(busy_o), 128'd0);
        ref_enc(k, nc, msg, ect, etg);
        chk("R6 R4 R5 R8 ciphertext", 128'(ct_o), 128'(ect));
        chk("R7 R4 R5 R8 tag", tag_o, etg);
        @(negedge clk);
        chk("R9 done single cycle", 128'(done_o), 128'd0);
        chk("R9 tag held", tag_o, etg);
        if (interfere) chk("R3 no second operation", 128'(busy_o), 128'd0);
    endtask

    logic [127:0] lf_a = 128'h0123456789abcdeffedcba9876543210;
    function automatic logic [127:0] nxt(input logic [127:0] x);
        logic [127:0] y = x;
        y ^= y << 13; y ^= y >> 7; y ^= y << 17;
        return y;
    endfunction

    initial begin
        logic [7:0] f [32];
        f[0] = 0; f[1] = 1;
        for (int i = 2; i < 32; i++) f[i] = f[i-1] + f[i-2];
        for (int i = 0; i < 16; i++) begin
            c_lo[127 - 8*i -: 8] = f[i];
            c_hi[127 - 8*i -: 8] = f[16 + i];
        end
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 0;
            logic [7:0] af;
            for (int y = 1; y < 256; y++) if (b_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            af = 8'h63;
            for (int b = 0; b < 8; b++)
                af[b] = af[b] ^ inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8] ^ inv[(b+7)%8];
            sbt[x] = af;
        end

        repeat (3) @(negedge clk);
        chk("R1 reset busy", 128'(busy_o), 0);
        chk("R1 reset done", 128'(done_o), 0);
        chk("R1 reset ct", 128'(ct_o), 0);
        chk("R1 reset tag", tag_o, 0);
        rst_n = 1;

        run_op('0, '0, '0, 0);
        run_op('1, '1, '1, 0);
        for (int b = 0; b < 128; b++) run_op(128'd1 << b, 128'h5a5a, 32'h1234_5678, 0);
        for (int b = 0; b < 128; b++) run_op(128'h7, 128'd1 << b, 32'h0, 0);
        for (int b = 0; b < MW; b++) run_op(128'h99, 128'h42, MW'(1) << b, 0);
        for (int i = 0; i < 24; i++) begin
            logic [127:0] ka, na, ma;
            ka = nxt(lf_a); na = nxt(ka); ma = nxt(na); lf_a = ma;
            run_op(ka, na, ma[MW-1:0], i % 3 == 0);
        end

        // reset in mid-schedule abandons the operation (R1)
        @(negedge clk);
        start_i = 1; key_i = 128'h1; nonce_i = 128'h2; msg_i = 32'h3;
        @(negedge clk);
        start_i = 0;
        repeat (4) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk("R1 midrun busy", 128'(busy_o), 0);
        chk("R1 midrun tag", tag_o, 0);
        repeat (25) @(negedge clk);
        chk("R1 no done after abandon", 128'(done_o), 0);
        chk("R1 tag stays clear", tag_o, 0);
        run_op(128'hfeed, 128'hbeef, 32'hcafe_f00d, 0);

        ended = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule